// File: doc/BRIEF.md
# Reciprocal-Iteration Fixed-Point Divider

This block divides an unsigned numerator by a non-zero unsigned divisor and returns the quotient as an unsigned fixed-point number with 16 fraction bits. It does not use shift-and-subtract. It first shifts the divisor left until its top bit is set. It then starts from a fixed reciprocal guess and refines that guess with Newton iterations. The quotient comes from one last multiply of the scaled numerator by the reciprocal, followed by a right shift that undoes the normalization.

A single shared multiplier serves every step, with one product per clock. Each operation therefore takes the same number of cycles whatever the operands. The caller raises `start_i` for one cycle with the operands while the block is idle. The block raises `done_o` for one cycle when the quotient is ready. The caller must never present a zero divisor, because the block performs no check for it. Full accuracy is promised when the numerator is below twice the divisor, so that the quotient is below 2.0.

Top module: `recip_div`

## Requirements
- R1: After reset, and after a reset applied in the middle of an operation, `quot_o` reads 0 and `done_o` reads 0. No completion follows until a new start.
- R2: The operands are sampled on the clock edge where `start_i` is accepted. Later changes on `num_i` and `den_i` do not affect that result.
- R3: The divisor is normalized so that bit 31 of the 32-bit normalized register is set. Results are correct for every leading-zero count of the 16-bit divisor, from 0 to 15.
- R4: The reciprocal is loaded with 0x4D000000, which is about 1.2 in unsigned 2.30 format. Exactly ITERS (default 4) Newton steps follow, and each step uses two multiply cycles.
- R5: When num_i < 2·den_i, `quot_o` is within 1 LSB of floor(num_i·65536 / den_i). Bits 15:0 of `quot_o` are the fraction and bits 31:16 are the integer part.
- R6: `done_o` rises exactly 2·ITERS+3 clock edges (11 by default) after the edge that accepts `start_i`.
- R7: `done_o` stays high for exactly one cycle.
- R8: `start_i` is ignored while an operation is running. The running result and its timing are unchanged, and no extra completion is produced.
- R9: `quot_o` changes only on the edge where `done_o` rises, and it holds its value otherwise.
- R10: A `start_i` presented in the same cycle that `done_o` is high is accepted, so operations can run back to back.
- R11: A zero numerator gives a quotient of exactly 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division when the block is idle |
| num_i | input | 16 | Unsigned numerator |
| den_i | input | 16 | Unsigned divisor, must be non-zero |
| quot_o | output | 32 | Quotient with 16 integer and 16 fraction bits |
| done_o | output | 1 | One-cycle pulse when `quot_o` is updated |

## Verification
The vector table uses divisors that cover every leading-zero count, including 1 and 0x8000, where the normalized value is exactly one half and the reciprocal approaches its upper limit of 2.0. A wrong normalization or scaling shift would return a quotient off by a power of two. A misplaced product window would produce gross errors there. A missing or extra Newton step would change the latency and shift the result by many LSBs near the top of the range. A start pulse injected mid-operation checks that a busy block neither restarts nor emits a second completion. A start in the completion cycle checks that back-to-back use is not lost. A reset in mid-operation checks that no stale completion appears afterwards.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

   // Controller phases of one division
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_NORM,
      PH_STEP_A,
      PH_STEP_B,
      PH_FINAL,
      PH_SCALE
   } phase_t;

   // Left operand of the shared multiplier
   typedef enum logic [1:0] {
      OPA_DIV,
      OPA_CORR,
      OPA_NUM
   } opa_sel_t;

endpackage

// File: rtl/rdiv_lzc.sv
module rdiv_lzc #(
   parameter int W  = 16,
   parameter int CW = $clog2(W)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] zeros_o
);

   // Per-bit candidate counts; the highest set bit wins
   logic [CW-1:0] cand [W];
   logic [W-1:0]  hit;

   for (genvar gi = 0; gi < W; gi++) begin : g_bit
      assign cand[gi] = CW'(W - 1 - gi);
      assign hit[gi]  = vec_i[gi];
   end

   always_comb begin
      zeros_o = CW'(W - 1);
      for (int i = 0; i < W; i++) begin
         if (hit[i]) zeros_o = cand[i];
      end
   end

endmodule

// File: rtl/rdiv_mul.sv
module rdiv_mul #(
   parameter int W = 32
) (
   input  logic signed [W:0] a_i,
   input  logic signed [W:0] b_i,
   output logic        [W:0] hi_o
);

   // Returns product bits [2W-1 : W-1]: the upper word plus one guard bit
   function automatic logic [W:0] upper_window(input logic signed [W:0] a,
                                               input logic signed [W:0] b);
      logic signed [2*W+1:0] full;
      full = a * b;
      return full[2*W-1:W-1];
   endfunction

   assign hi_o = upper_window(a_i, b_i);

endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
   import rdiv_pkg::*;
#(
   parameter int ITERS = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   output phase_t   phase_o,
   output opa_sel_t opa_o
);

   localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
   localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(ITERS - 1);

   phase_t          phase_q;
   logic [CNT_W-1:0] it_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         it_q    <= '0;
      end else begin
         case (phase_q)
            PH_IDLE:   if (start_i) phase_q <= PH_NORM;
            PH_NORM: begin
               it_q    <= '0;
               phase_q <= PH_STEP_A;
            end
            PH_STEP_A: phase_q <= PH_STEP_B;
            PH_STEP_B: begin
               if (it_q == LAST_IT) begin
                  phase_q <= PH_FINAL;
               end else begin
                  it_q    <= it_q + 1'b1;
                  phase_q <= PH_STEP_A;
               end
            end
            PH_FINAL:  phase_q <= PH_SCALE;
            PH_SCALE:  phase_q <= PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      case (phase_q)
         PH_STEP_B: opa_o = OPA_CORR;
         PH_FINAL:  opa_o = OPA_NUM;
         default:   opa_o = OPA_DIV;
      endcase
   end

   assign phase_o = phase_q;

endmodule

// File: rtl/recip_div.sv
module recip_div
   import rdiv_pkg::*;
#(
   parameter int          NUM_W    = 16,
   parameter int          DEN_W    = 16,
   parameter int          ITERS    = 4,
   parameter logic [7:0]  SEED_TOP = 8'h4D
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [NUM_W-1:0]       num_i,
   input  logic [DEN_W-1:0]       den_i,
   output logic [2*DEN_W-1:0]     quot_o,
   output logic                   done_o
);

   localparam int REG_W  = 2 * DEN_W;
   localparam int FRAC_W = REG_W - NUM_W;
   localparam int LZ_W   = $clog2(DEN_W);
   localparam logic [REG_W-1:0] SEED = {SEED_TOP, {(REG_W-8){1'b0}}};

   // Elaboration-time parameter checks
   if (DEN_W < 8) begin : g_bad_den
      $error("recip_div: DEN_W must be at least 8");
   end
   if (NUM_W > REG_W) begin : g_bad_num
      $error("recip_div: NUM_W must not exceed 2*DEN_W");
   end
   if (ITERS < 1) begin : g_bad_iters
      $error("recip_div: ITERS must be at least 1");
   end

   phase_t           phase;
   opa_sel_t         opa_sel;

   logic [NUM_W-1:0] num_q;
   logic [DEN_W-1:0] den_q;
   logic [REG_W-1:0] dnorm_q;
   logic [REG_W-1:0] rcp_q;
   logic [REG_W-1:0] corr_q;
   logic [REG_W-1:0] mnum_q;
   logic [REG_W:0]   prod_q;
   logic [LZ_W-1:0]  sh_q;
   logic [REG_W-1:0] quot_q;
   logic             done_q;

   logic [LZ_W-1:0]  lz;
   logic [REG_W:0]   op_a;
   logic [REG_W:0]   op_b;
   logic [REG_W:0]   mul_hi;
   logic [REG_W-1:0] upper;
   logic [REG_W-1:0] upper_x4;
   logic [REG_W:0]   scaled;

   rdiv_ctrl #(.ITERS(ITERS)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .phase_o (phase),
      .opa_o   (opa_sel)
   );

   rdiv_lzc #(.W(DEN_W), .CW(LZ_W)) u_lzc (
      .vec_i   (den_q),
      .zeros_o (lz)
   );

   always_comb begin
      case (opa_sel)
         OPA_CORR: op_a = {corr_q[REG_W-1], corr_q};
         OPA_NUM:  op_a = {1'b0, mnum_q};
         default:  op_a = {1'b0, dnorm_q};
      endcase
   end
   assign op_b = {1'b0, rcp_q};

   rdiv_mul #(.W(REG_W)) u_mul (
      .a_i  (op_a),
      .b_i  (op_b),
      .hi_o (mul_hi)
   );

   assign upper    = mul_hi[REG_W:1];
   assign upper_x4 = upper << 2;
   assign scaled   = prod_q >> sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q   <= '0;
         den_q   <= '0;
         dnorm_q <= '0;
         rcp_q   <= '0;
         corr_q  <= '0;
         mnum_q  <= '0;
         prod_q  <= '0;
         sh_q    <= '0;
         quot_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start_i) begin
                  num_q <= num_i;
                  den_q <= den_i;
               end
            end
            PH_NORM: begin
               dnorm_q <= {den_q, {DEN_W{1'b0}}} << lz;
               sh_q    <= LZ_W'(DEN_W - 1) - lz;
               rcp_q   <= SEED;
               mnum_q  <= {num_q, {FRAC_W{1'b0}}};
            end
            PH_STEP_A: corr_q <= '0 - upper_x4;
            PH_STEP_B: rcp_q  <= rcp_q + upper;
            PH_FINAL:  prod_q <= mul_hi;
            PH_SCALE: begin
               quot_q <= scaled[REG_W-1:0];
               done_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign quot_o = quot_q;
   assign done_o = done_q;

endmodule

// File: rtl/rdiv_chk.sv
module rdiv_chk #(
   parameter int         NUM_W    = 16,
   parameter int         DEN_W    = 16,
   parameter int         ITERS    = 4,
   parameter logic [7:0] SEED_TOP = 8'h4D
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic [NUM_W-1:0]     num_i,
   input logic [DEN_W-1:0]     den_i,
   input logic [2*DEN_W-1:0]   quot_o,
   input logic                 done_o,
   input logic [2*DEN_W-1:0]   dnorm_i,
   input logic [2*DEN_W-1:0]   rcp_i
);

   localparam int REG_W  = 2 * DEN_W;
   localparam int FRAC_W = REG_W - NUM_W;
   localparam int LAT    = 2 * ITERS + 3;
   localparam int CNT_W  = $clog2(LAT + 1);
   localparam logic [REG_W-1:0] SEED = {SEED_TOP, {(REG_W-8){1'b0}}};

   logic             ck_bsy;
   logic [CNT_W-1:0] ck_cnt;
   logic             fin_q;
   logic [NUM_W-1:0] cap_n;
   logic [DEN_W-1:0] cap_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_bsy <= 1'b0;
         ck_cnt <= '0;
         fin_q  <= 1'b0;
         cap_n  <= '0;
         cap_d  <= '0;
      end else begin
         fin_q <= 1'b0;
         if (!ck_bsy) begin
            if (start_i) begin
               ck_bsy <= 1'b1;
               ck_cnt <= '0;
               cap_n  <= num_i;
               cap_d  <= den_i;
            end
         end else if (ck_cnt == CNT_W'(LAT - 1)) begin
            ck_bsy <= 1'b0;
            fin_q  <= 1'b1;
         end else begin
            ck_cnt <= ck_cnt + 1'b1;
         end
      end
   end

   logic [REG_W-1:0] m_ck;
   logic [REG_W-1:0] exact;
   logic [REG_W-1:0] diff;
   logic             in_range;
   logic             close;

   always_comb begin
      m_ck     = {cap_n, {FRAC_W{1'b0}}};
      exact    = (cap_d != '0) ? (m_ck / REG_W'(cap_d)) : '0;
      diff     = (quot_o >= exact) ? (quot_o - exact) : (exact - quot_o);
      close    = (diff <= REG_W'(1));
      in_range = ((REG_W+1)'(cap_n) < ((REG_W+1)'(cap_d) << 1));
   end

   AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |-> done_o);                                        // R6
   AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> fin_q);                                        // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                      // R7
   AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(quot_o));                             // R9
   AST_QUOT_ACCURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && in_range) |-> close);                          // R5
   AST_NORM_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_bsy && ck_cnt != '0) |-> dnorm_i[REG_W-1]);           // R3
   AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_bsy && ck_cnt == CNT_W'(1)) |-> (rcp_i == SEED));     // R4

endmodule

bind recip_div rdiv_chk #(
   .NUM_W    (NUM_W),
   .DEN_W    (DEN_W),
   .ITERS    (ITERS),
   .SEED_TOP (SEED_TOP)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .num_i   (num_i),
   .den_i   (den_i),
   .quot_o  (quot_o),
   .done_o  (done_o),
   .dnorm_i (dnorm_q),
   .rcp_i   (rcp_q)
);

// File: tb/recip_div_tb.sv
module recip_div_tb_top;

   localparam int ITERS = 4;
   localparam int LAT   = 2 * ITERS + 3;
   localparam int NV    = 19;

   // Each entry: numerator in bits 31:16, divisor in bits 15:0
   localparam logic [31:0] VEC [NV] = '{
      32'h0001_0001, 32'h0003_0002, 32'h0005_0004, 32'h000F_000A,
      32'h001F_0011, 32'h0050_0030, 32'h007F_0041, 32'h00FF_0080,
      32'h01FF_0101, 32'h03E8_03E7, 32'h07FF_0400, 32'h0ABC_09F1,
      32'h1234_1111, 32'h3FFF_2001, 32'h7000_5555, 32'hFFFF_8000,
      32'h0000_1234, 32'hFFFE_FFFF, 32'hFFFF_FFFF
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] num = '0;
   logic [15:0] den = 16'd1;
   logic [31:0] quot;
   logic        done;

   int errs = 0;
   int checks = 0;

   always #5 clk = ~clk;

   recip_div dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .num_i   (num),
      .den_i   (den),
      .quot_o  (quot),
      .done_o  (done)
   );

   function automatic logic [31:0] ref_q(input logic [15:0] n, input logic [15:0] d);
      logic [31:0] m;
      m = {n, 16'h0000};
      return m / {16'h0000, d};
   endfunction

   function automatic bit near(input logic [31:0] a, input logic [31:0] b);
      return ((a >= b) ? (a - b) : (b - a)) <= 32'd1;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Call at a negedge; returns at the negedge where done is seen
   task automatic launch(input logic [15:0] n, input logic [15:0] d,
                         output logic [31:0] q, output int lat);
      num = n;
      den = d;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      num = ~n;
      den = ~d;
      lat = 0;
      do begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end while (!done && lat < 40);
      q = quot;
   endtask

   initial begin
      #(200000 * 10);
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [31:0] q;
      logic [31:0] qa;
      logic [31:0] qh;
      int          lat;
      bit          extra;
      bit          moved;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 done in reset", {31'b0, done}, 32'd0);
      check(quot == 32'd0, "R1 quotient in reset", quot, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R5 accuracy, R3 all leading-zero counts, R2 input capture
      for (int i = 0; i < NV; i++) begin
         logic [15:0] vn;
         logic [15:0] vd;
         vn = VEC[i][31:16];
         vd = VEC[i][15:0];
         launch(vn, vd, q, lat);
         check(near(q, ref_q(vn, vd)), "R5 R3 R2 quotient", q, ref_q(vn, vd));
         check(lat == LAT, "R6 R4 latency", 32'(lat), 32'(LAT));
         if (vn == 16'd0) check(q == 32'd0, "R11 zero numerator", q, 32'd0);
         @(negedge clk);
         check(done == 1'b0, "R7 done width", {31'b0, done}, 32'd0);
      end

      // R8: start pulse while busy is ignored
      num = 16'h7000;
      den = 16'h5555;
      start = 1'b1;
      @(posedge clk);
      lat = 0;
      @(negedge clk);
      start = 1'b0;
      do begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (lat == 3) begin
            num = 16'h0001;
            den = 16'h0001;
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
      end while (!done && lat < 40);
      start = 1'b0;
      qa = quot;
      check(near(qa, ref_q(16'h7000, 16'h5555)), "R8 busy start ignored", qa,
            ref_q(16'h7000, 16'h5555));
      check(lat == LAT, "R8 latency unchanged", 32'(lat), 32'(LAT));

      // R8 / R9: no extra completion, quotient held
      qh = quot;
      extra = 1'b0;
      moved = 1'b0;
      repeat (15) begin
         @(negedge clk);
         if (done) extra = 1'b1;
         if (quot != qh) moved = 1'b1;
      end
      check(!extra, "R8 no second done", {31'b0, extra}, 32'd0);
      check(!moved, "R9 quotient held", quot, qh);

      // R10: back-to-back start in the done cycle
      launch(16'h0ABC, 16'h09F1, q, lat);
      launch(16'h3FFF, 16'h2001, q, lat);
      check(near(q, ref_q(16'h3FFF, 16'h2001)), "R10 back-to-back result", q,
            ref_q(16'h3FFF, 16'h2001));
      check(lat == LAT, "R10 back-to-back latency", 32'(lat), 32'(LAT));
      @(negedge clk);

      // R1: reset during an operation
      num = 16'h00FF;
      den = 16'h0080;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(quot == 32'd0, "R1 quotient after mid reset", quot, 32'd0);
      check(done == 1'b0, "R1 done after mid reset", {31'b0, done}, 32'd0);
      rst_n = 1'b1;
      extra = 1'b0;
      repeat (20) begin
         @(negedge clk);
         if (done) extra = 1'b1;
      end
      check(!extra, "R1 no stale completion", {31'b0, extra}, 32'd0);

      // Recovery after reset
      launch(16'hFFFF, 16'h8000, q, lat);
      check(near(q, ref_q(16'hFFFF, 16'h8000)), "R5 after reset", q,
            ref_q(16'hFFFF, 16'h8000));

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule